// File: doc/BRIEF.md
# Interrupt Acceptance and Gate Check

This block decides, each clock cycle, which of up to four pending events is taken next and through which vector. The four sources are a synchronous exception carrying its vector, a software-raised interrupt carrying its vector, a rising edge on a non-maskable input, and a maskable external request carrying its vector. It holds a 256-entry gate table. Each entry says whether the gate is present, whether it is an interrupt-type or a trap-type gate, and which privilege level may raise it from software.

The chosen event's vector is looked up in the table. A software request from a privilege level numerically above the gate's level is turned into the general protection fault (vector 13), and so is any event that lands on a gate that is not present. The block then reports the acceptance with a one-cycle strobe, the source, the final vector, and a request to clear the enable flag when the final gate is interrupt-type. A requester holds its request until it sees the strobe naming its own source. Non-maskable events are latched, use vector 2, ignore the enable flag, and stay shut out between an accepted one and the next return-from-interrupt pulse.

Top module: `irq_gate_arbiter`

## Requirements
- R1: After reset `take_o` is low, and it stays low while no event is pending.
- R2: When several events are pending in the same cycle, the source is chosen in this order: exception (source code 0), then software interrupt (1), then non-maskable (2), then maskable external (3). Lower-priority requests stay pending and are taken in later cycles.
- R3: An exception request is accepted with its own vector whatever the state of `ie_i`.
- R4: A software request is accepted with its own vector when `cpl_i` is less than or equal to the gate's privilege level. Otherwise it is accepted with vector 13.
- R5: A maskable external request is accepted only while `ie_i` is 1. While `ie_i` is 0 it is held off and causes no strobe.
- R6: A rising edge on `nmi_i` is accepted with vector 2 even while `ie_i` is 0.
- R7: After a non-maskable event is accepted, further non-maskable edges are latched but not accepted. A pulse on `iret_i` reopens acceptance, and a latched edge is then taken in the same cycle as the pulse.
- R8: `clr_ie_o` equals the interrupt-type bit of the gate of the final vector (the vector-13 gate when a fault replaced the event).
- R9: An event whose gate has its present bit clear is accepted with vector 13 instead of its own vector.
- R10: A table write stores `tbl_data_i` with bit 3 as the present bit, bit 2 as the gate type (1 for interrupt-type, 0 for trap-type) and bits 1:0 as the gate privilege level.
- R11: `take_o` is a single-cycle strobe. It rises on the first clock edge that samples the event, and `take_src_o`, `take_vec_o` and `clr_ie_o` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Synchronous exception pending |
| exc_vec_i | input | 8 | Exception vector |
| swi_req_i | input | 1 | Software interrupt pending |
| swi_vec_i | input | 8 | Software interrupt vector |
| nmi_i | input | 1 | Non-maskable input, acted on at its rising edge |
| ext_req_i | input | 1 | Maskable external request pending |
| ext_vec_i | input | 8 | External request vector |
| ie_i | input | 1 | Interrupt-enable flag |
| cpl_i | input | 2 | Current privilege level |
| iret_i | input | 1 | Return-from-interrupt pulse |
| tbl_we_i | input | 1 | Gate table write enable |
| tbl_vec_i | input | 8 | Gate table write index |
| tbl_data_i | input | 4 | Gate entry {present, type, level} |
| take_o | output | 1 | Acceptance strobe |
| take_src_o | output | 2 | Source of the accepted event |
| take_vec_o | output | 8 | Final vector |
| clr_ie_o | output | 1 | Request to clear the enable flag |

## Verification
Every result is registered once. An event, or an `ie_i` or `iret_i` change, driven before one clock edge shows on the outputs just after that edge. The same holds for the rising edge of `nmi_i`, because a live edge goes straight into arbitration. A table write takes effect at its own edge and is read by events sampled at later edges. The bench drives inputs on falling edges and reads the outputs on the next falling edge. Held-off cases are watched for several cycles, and each requester drops its request on the falling edge at which it sees its own strobe.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   localparam int GATE_PL_W = 2;

   typedef enum logic [1:0] {
      SRC_EXC = 2'd0,
      SRC_SWI = 2'd1,
      SRC_NMI = 2'd2,
      SRC_EXT = 2'd3
   } irq_src_e;

   typedef struct packed {
      logic                 present;
      logic                 itype;
      logic [GATE_PL_W-1:0] dpl;
   } gate_t;

   localparam int GATE_W = $bits(gate_t);

endpackage

// File: rtl/irq_gate_table.sv
module irq_gate_table
   import irq_gate_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int NUM_RD = 2
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            we_i,
   input  logic [VEC_W-1:0]                wr_vec_i,
   input  gate_t                           wr_entry_i,
   input  logic [NUM_RD-1:0][VEC_W-1:0]    rd_vec_i,
   output gate_t [NUM_RD-1:0]              rd_entry_o
);
   localparam int NUM_VEC = 1 << VEC_W;

   if (NUM_RD < 1) begin : g_bad_rd
      $error("irq_gate_table: NUM_RD must be at least 1");
   end

   gate_t rows_q [NUM_VEC];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < NUM_VEC; i++) rows_q[i] <= '0;
      end else if (we_i) begin
         rows_q[wr_vec_i] <= wr_entry_i;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_entry_o[p] = rows_q[rd_vec_i[p]];
   end

endmodule

// File: rtl/irq_event_select.sv
module irq_event_select
   import irq_gate_pkg::*;
#(
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              exc_req_i,
   input  logic [VEC_W-1:0]  exc_vec_i,
   input  logic              swi_req_i,
   input  logic [VEC_W-1:0]  swi_vec_i,
   input  logic              nmi_i,
   input  logic              ext_req_i,
   input  logic [VEC_W-1:0]  ext_vec_i,
   input  logic              ie_i,
   input  logic              iret_i,
   output logic              sel_valid_o,
   output irq_src_e          sel_src_o,
   output logic [VEC_W-1:0]  sel_vec_o
);
   logic nmi_prev_q, nmi_pend_q, nmi_blk_q;
   logic nmi_edge, nmi_pend, nmi_open, nmi_take;

   assign nmi_edge = nmi_i & ~nmi_prev_q;
   assign nmi_pend = nmi_pend_q | nmi_edge;
   assign nmi_open = ~nmi_blk_q | iret_i;

   always_comb begin
      sel_valid_o = 1'b1;
      sel_src_o   = SRC_EXC;
      sel_vec_o   = exc_vec_i;
      if (exc_req_i) begin
         sel_src_o = SRC_EXC;
         sel_vec_o = exc_vec_i;
      end else if (swi_req_i) begin
         sel_src_o = SRC_SWI;
         sel_vec_o = swi_vec_i;
      end else if (nmi_pend && nmi_open) begin
         sel_src_o = SRC_NMI;
         sel_vec_o = VEC_W'(NMI_VEC);
      end else if (ext_req_i && ie_i) begin
         sel_src_o = SRC_EXT;
         sel_vec_o = ext_vec_i;
      end else begin
         sel_valid_o = 1'b0;
      end
   end

   assign nmi_take = sel_valid_o && (sel_src_o == SRC_NMI);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nmi_prev_q <= 1'b0;
         nmi_pend_q <= 1'b0;
         nmi_blk_q  <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_i;
         nmi_pend_q <= nmi_take ? 1'b0 : nmi_pend;
         if (nmi_take)    nmi_blk_q <= 1'b1;
         else if (iret_i) nmi_blk_q <= 1'b0;
      end
   end

   // R7: a latched edge is never taken while acceptance is shut
   a_r7_nmi_shut: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_blk_q && !iret_i) |-> !nmi_take);

   // R2: an exception always wins arbitration
   a_r2_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_req_i |-> (sel_valid_o && sel_src_o == SRC_EXC));

endmodule

// File: rtl/irq_gate_check.sv
module irq_gate_check
   import irq_gate_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int GP_VEC = 13
) (
   input  irq_src_e                 src_i,
   input  logic [VEC_W-1:0]         vec_i,
   input  logic [GATE_PL_W-1:0]     cpl_i,
   input  gate_t                    entry_i,
   input  gate_t                    gp_entry_i,
   output logic [VEC_W-1:0]         vec_o,
   output logic                     clr_ie_o
);
   logic priv_fail, fault;
   logic unused_gp_bits;

   assign priv_fail = (src_i == SRC_SWI) && (cpl_i > entry_i.dpl);
   assign fault     = !entry_i.present || priv_fail;
   assign vec_o     = fault ? VEC_W'(GP_VEC) : vec_i;
   assign clr_ie_o  = fault ? gp_entry_i.itype : entry_i.itype;

   assign unused_gp_bits = ^{gp_entry_i.present, gp_entry_i.dpl};

endmodule

// File: rtl/irq_gate_arbiter.sv
module irq_gate_arbiter
   import irq_gate_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int FIXED_VECS = 32,
   parameter int GP_VEC     = 13,
   parameter int NMI_VEC    = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  exc_req_i,
   input  logic [VEC_W-1:0]      exc_vec_i,
   input  logic                  swi_req_i,
   input  logic [VEC_W-1:0]      swi_vec_i,
   input  logic                  nmi_i,
   input  logic                  ext_req_i,
   input  logic [VEC_W-1:0]      ext_vec_i,
   input  logic                  ie_i,
   input  logic [GATE_PL_W-1:0]  cpl_i,
   input  logic                  iret_i,
   input  logic                  tbl_we_i,
   input  logic [VEC_W-1:0]      tbl_vec_i,
   input  logic [GATE_W-1:0]     tbl_data_i,
   output logic                  take_o,
   output logic [1:0]            take_src_o,
   output logic [VEC_W-1:0]      take_vec_o,
   output logic                  clr_ie_o
);
   localparam int NUM_VEC = 1 << VEC_W;
   localparam int RD_SEL  = 0;
   localparam int RD_GP   = 1;

   if (NUM_VEC < FIXED_VECS) begin : g_bad_width
      $error("irq_gate_arbiter: VEC_W too narrow for the fixed vectors");
   end
   if (GP_VEC >= FIXED_VECS || NMI_VEC >= FIXED_VECS) begin : g_bad_fixed
      $error("irq_gate_arbiter: fault and NMI vectors must be fixed vectors");
   end

   logic                    sel_valid;
   irq_src_e                sel_src;
   logic [VEC_W-1:0]        sel_vec;
   logic [1:0][VEC_W-1:0]   rd_vec;
   gate_t [1:0]             rd_entry;
   logic [VEC_W-1:0]        fin_vec;
   logic                    fin_clr;

   irq_event_select #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_select (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .exc_req_i  (exc_req_i),
      .exc_vec_i  (exc_vec_i),
      .swi_req_i  (swi_req_i),
      .swi_vec_i  (swi_vec_i),
      .nmi_i      (nmi_i),
      .ext_req_i  (ext_req_i),
      .ext_vec_i  (ext_vec_i),
      .ie_i       (ie_i),
      .iret_i     (iret_i),
      .sel_valid_o(sel_valid),
      .sel_src_o  (sel_src),
      .sel_vec_o  (sel_vec)
   );

   assign rd_vec[RD_SEL] = sel_vec;
   assign rd_vec[RD_GP]  = VEC_W'(GP_VEC);

   irq_gate_table #(.VEC_W(VEC_W), .NUM_RD(2)) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (tbl_we_i),
      .wr_vec_i  (tbl_vec_i),
      .wr_entry_i(gate_t'(tbl_data_i)),
      .rd_vec_i  (rd_vec),
      .rd_entry_o(rd_entry)
   );

   irq_gate_check #(.VEC_W(VEC_W), .GP_VEC(GP_VEC)) u_check (
      .src_i     (sel_src),
      .vec_i     (sel_vec),
      .cpl_i     (cpl_i),
      .entry_i   (rd_entry[RD_SEL]),
      .gp_entry_i(rd_entry[RD_GP]),
      .vec_o     (fin_vec),
      .clr_ie_o  (fin_clr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         take_o     <= 1'b0;
         take_src_o <= 2'd0;
         take_vec_o <= '0;
         clr_ie_o   <= 1'b0;
      end else begin
         take_o     <= sel_valid;
         take_src_o <= sel_src;
         take_vec_o <= fin_vec;
         clr_ie_o   <= sel_valid & fin_clr;
      end
   end

   // R5: an external acceptance implies the enable flag was set
   a_r5_ext_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && take_src_o == 2'(SRC_EXT)) |-> $past(ie_i));

   // R3, R9: exception keeps its vector or becomes the fault vector
   a_r3_exc_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && take_src_o == 2'(SRC_EXC)) |->
         (take_vec_o == $past(exc_vec_i) || take_vec_o == VEC_W'(GP_VEC)));

   // R6: non-maskable acceptance uses its fixed vector
   a_r6_nmi_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && take_src_o == 2'(SRC_NMI)) |->
         (take_vec_o == VEC_W'(NMI_VEC) || take_vec_o == VEC_W'(GP_VEC)));

   // R7: two back-to-back NMI acceptances need a return pulse between them
   a_r7_nmi_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && take_src_o == 2'(SRC_NMI)) |=>
         (!(take_o && take_src_o == 2'(SRC_NMI)) || $past(iret_i)));

   // R2: a sampled exception request decides the next acceptance
   a_r2_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(exc_req_i) |-> (take_o && take_src_o == 2'(SRC_EXC)));

endmodule

// File: tb/irq_gate_arbiter_tb.sv
`timescale 1ns/1ps
module irq_gate_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exc_req = 0, swi_req = 0, nmi = 0, ext_req = 0;
   logic [7:0] exc_vec = 0, swi_vec = 0, ext_vec = 0;
   logic       ie = 0, iret = 0, tbl_we = 0;
   logic [1:0] cpl = 0;
   logic [7:0] tbl_vec = 0;
   logic [3:0] tbl_data = 0;
   logic       take, clr_ie;
   logic [1:0] take_src;
   logic [7:0] take_vec;
   int         errors = 0;
   int         checks = 0;

   always #10 clk = ~clk;

   irq_gate_arbiter dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .exc_req_i(exc_req), .exc_vec_i(exc_vec),
      .swi_req_i(swi_req), .swi_vec_i(swi_vec),
      .nmi_i(nmi),
      .ext_req_i(ext_req), .ext_vec_i(ext_vec),
      .ie_i(ie), .cpl_i(cpl), .iret_i(iret),
      .tbl_we_i(tbl_we), .tbl_vec_i(tbl_vec), .tbl_data_i(tbl_data),
      .take_o(take), .take_src_o(take_src), .take_vec_o(take_vec),
      .clr_ie_o(clr_ie)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_take(string tag, int src, int vec, int clr);
      chk({tag, " take"}, int'(take), 1);
      chk({tag, " src"},  int'(take_src), src);
      chk({tag, " vec"},  int'(take_vec), vec);
      chk({tag, " clr"},  int'(clr_ie), clr);
   endtask

   // R10: data bit 3 present, bit 2 interrupt-type, bits 1:0 level
   task automatic wr_gate(int v, bit p, bit it, int pl);
      @(negedge clk);
      tbl_we = 1; tbl_vec = 8'(v); tbl_data = {p, it, 2'(pl)};
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic t_reset();
      chk("R1 idle after reset", int'(take), 0);
      @(negedge clk);
      chk("R1 idle no event", int'(take), 0);
   endtask

   task automatic t_exception();
      ie = 0; exc_req = 1; exc_vec = 14;
      @(negedge clk);
      expect_take("R3 R8 R11 exc14 ie0", 0, 14, 1);
      exc_req = 0;
      @(negedge clk);
      chk("R11 strobe single cycle", int'(take), 0);
   endtask

   task automatic t_swi(int v, int pl, int evec, int eclr, string tag);
      cpl = 2'(pl); swi_req = 1; swi_vec = 8'(v);
      @(negedge clk);
      expect_take(tag, 1, evec, eclr);
      swi_req = 0;
      @(negedge clk);
   endtask

   task automatic t_ext();
      ie = 0; ext_req = 1; ext_vec = 8'h20;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R5 held off ie0", int'(take), 0);
      end
      ie = 1;
      @(negedge clk);
      expect_take("R5 R8 ext 0x20", 3, 32, 1);
      ext_vec = 8'h21;
      @(negedge clk);
      expect_take("R8 ext 0x21 trap", 3, 33, 0);
      ext_req = 0; ie = 0;
      @(negedge clk);
   endtask

   task automatic t_nmi();
      ie = 0; nmi = 1;
      @(negedge clk);
      expect_take("R6 nmi ie0", 2, 2, 1);
      nmi = 0;
      @(negedge clk);
      nmi = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7 nmi shut", int'(take), 0);
      end
      iret = 1;
      @(negedge clk);
      iret = 0;
      expect_take("R7 latched nmi after return", 2, 2, 1);
      nmi = 0;
      @(negedge clk);
      chk("R7 no repeat", int'(take), 0);
      iret = 1;
      @(negedge clk);
      iret = 0;
      chk("R7 return with nothing latched", int'(take), 0);
   endtask

   task automatic t_absent();
      exc_req = 1; exc_vec = 8'h40;
      @(negedge clk);
      expect_take("R9 absent exc", 0, 13, 1);
      exc_req = 0;
      @(negedge clk);
      t_swi(8'h40, 0, 13, 1, "R9 absent swi");
   endtask

   task automatic t_priority();
      cpl = 0; ie = 1;
      exc_req = 1; exc_vec = 3;
      swi_req = 1; swi_vec = 8'h80;
      ext_req = 1; ext_vec = 8'h21;
      nmi = 1;
      @(negedge clk);
      expect_take("R2 first exc", 0, 3, 0);
      exc_req = 0;
      @(negedge clk);
      expect_take("R2 second swi", 1, 128, 1);
      swi_req = 0;
      @(negedge clk);
      expect_take("R2 third nmi", 2, 2, 1);
      @(negedge clk);
      expect_take("R2 fourth ext", 3, 33, 0);
      ext_req = 0; nmi = 0; ie = 0;
      @(negedge clk);
      chk("R2 drained", int'(take), 0);
   endtask

   initial begin
      #4_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         tbl_we = 1; tbl_vec = 8'(v); tbl_data = 4'b1000;
      end
      @(negedge clk);
      tbl_we = 0;
      wr_gate(14,    1, 1, 0);
      wr_gate(13,    1, 1, 0);
      wr_gate(2,     1, 1, 0);
      wr_gate(8'h80, 1, 1, 3);
      wr_gate(8'h81, 1, 0, 0);
      wr_gate(8'h20, 1, 1, 0);
      wr_gate(8'h21, 1, 0, 0);
      wr_gate(8'h40, 0, 1, 3);
      t_exception();
      t_swi(8'h80, 3, 128, 1, "R4 swi pl3 gate3");
      t_swi(8'h80, 2, 128, 1, "R4 swi pl2 gate3");
      t_swi(8'h81, 3, 13,  1, "R4 R8 swi pl3 gate0 fault");
      t_swi(8'h81, 1, 13,  1, "R4 swi pl1 gate0 fault");
      t_swi(8'h81, 0, 129, 0, "R4 R8 swi pl0 trap gate");
      t_ext();
      t_nmi();
      t_absent();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule